// File: doc/BRIEF.md
# Cascadable Serial Channel-Select Controller

This block drives the enables of an eight-way switch array from a three-wire serial port: a select strobe, a serial clock and a data line. While the strobe is high, each rising edge of the serial clock moves the data line into a four-bit frame register. The frame is an enable flag followed by a three-bit channel code, most significant bit first. When the strobe falls, the frame is committed. The switch that was closed opens at once. Every enable then stays low for a programmable number of system-clock cycles, and only after that gap does the newly chosen switch close. This keeps two switches from ever conducting together.

The bit leaving the far end of the frame register is presented on a serial output, and an output enable marks when the pin should be driven. A second controller can take its data from this output, so a chain of controllers shares one serial port. All three serial inputs are asynchronous to the fast system clock. Each passes through a two-flop synchronizer, and edges are found on the synchronized copies. An input change therefore takes effect on the third system-clock edge after it.

Top module: `chsel_ctrl`

## Requirements
- R1: While the synchronized strobe is high, each synchronized rising edge of the serial clock shifts the data line into the frame register. The frame order is enable flag first, then code bits B2, B1, B0. Each input change acts on the third system-clock edge after it.
- R2: A committed frame with enable flag 1 drives exactly one switch enable, at bit index {B2,B1,B0} in plain binary (000 is bit 0, 111 is bit 7).
- R3: A committed frame with enable flag 0 leaves all eight switch enables low, whatever the code bits are.
- R4: One cycle after a strobe falling edge is detected, all switch enables are low. They stay low for GAP_CYC system cycles (default 4), and the new selection then appears. At no time is more than one enable high.
- R5: A selection holds unchanged until the next strobe falling edge.
- R6: The serial output shows the bit that entered the frame register four serial-clock rises earlier, so the first bit fed in appears after the fourth rise. It changes only on a shift.
- R7: The serial output enable is high only while the synchronized strobe is high. It is low, meaning high impedance, while the strobe is low.
- R8: If more than four serial-clock rises occur in one strobe-high window, only the last four bits are committed.
- R9: During and after reset, the frame register is clear, all switch enables are low and the serial output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_i | input | 1 | Select strobe, asynchronous, high while a frame is shifted |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out, last stage of the frame register |
| dout_oe_o | output | 1 | Drive enable for dout_o, low means high impedance |
| sw_en_o | output | 8 | One-hot-or-zero switch enables |

## Verification
The assertions check on every cycle that at most one enable is high. They also check that a strobe fall clears the enables on the next edge, that a live selection holds until a fall, and that the serial output moves only on a shift. Which channel ends up selected cannot be seen by a single property. Neither can the exact length of the all-off gap, the handling of surplus clock edges or the four-rise cascade delay. These are shown by the bench's reference model and its frame scenarios.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  typedef enum logic {
    SEQ_HOLD = 1'b0,
    SEQ_GAP  = 1'b1
  } seq_state_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  import chsel_pkg::*;

  logic [W-1:0] stage_q [SYNC_STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[SYNC_STAGES-1];
    end
  end

  assign level_o = stage_q[SYNC_STAGES-1];

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise_o[g] =  level_o[g] & ~prev_q[g];
    assign fall_o[g] = ~level_o[g] &  prev_q[g];
  end
endmodule

// File: rtl/chsel_shreg.sv
module chsel_shreg #(
  parameter int unsigned FRAME_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               tail_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], bit_i};
  end

  assign frame_o = sr_q;
  assign tail_o  = sr_q[FRAME_W-1];
endmodule

// File: rtl/chsel_seq.sv
module chsel_seq #(
  parameter int unsigned N_CH    = 8,
  parameter int unsigned GAP_CYC = 4,
  localparam int unsigned CODE_W = $clog2(N_CH),
  localparam int unsigned CNT_W  = $clog2(GAP_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [N_CH-1:0]   sw_en_o
);
  import chsel_pkg::*;

  seq_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [N_CH-1:0]  pend_q, dec;

  for (genvar g = 0; g < N_CH; g++) begin : g_dec
    assign dec[g] = en_i && (code_i == CODE_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_HOLD;
      cnt_q   <= '0;
      pend_q  <= '0;
      sw_en_o <= '0;
    end else if (commit_i) begin
      // break first, restart the gap even if one is running
      sw_en_o <= '0;
      pend_q  <= dec;
      cnt_q   <= CNT_W'(GAP_CYC);
      state_q <= SEQ_GAP;
    end else if (state_q == SEQ_GAP) begin
      if (cnt_q == CNT_W'(1)) begin
        sw_en_o <= pend_q;
        cnt_q   <= '0;
        state_q <= SEQ_HOLD;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl #(
  parameter int unsigned N_CH    = 8,
  parameter int unsigned GAP_CYC = 4,
  localparam int unsigned CODE_W  = $clog2(N_CH),
  localparam int unsigned FRAME_W = CODE_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic            cs_i,
  input  logic            din_i,
  output logic            dout_o,
  output logic            dout_oe_o,
  output logic [N_CH-1:0] sw_en_o
);
  localparam int unsigned IDX_SCLK = 2;
  localparam int unsigned IDX_CS   = 1;
  localparam int unsigned IDX_DIN  = 0;

  logic [2:0]         lvl, rise, fall;
  logic               sclk_rise, cs_fall, cs_high, shift;
  logic [FRAME_W-1:0] frame;

  chsel_sync #(.W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({sclk_i, cs_i, din_i}),
    .level_o(lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sclk_rise = rise[IDX_SCLK];
  assign cs_fall   = fall[IDX_CS];
  assign cs_high   = lvl[IDX_CS];
  assign shift     = sclk_rise & cs_high;

  chsel_shreg #(.FRAME_W(FRAME_W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift),
    .bit_i  (lvl[IDX_DIN]),
    .frame_o(frame),
    .tail_o (dout_o)
  );

  chsel_seq #(.N_CH(N_CH), .GAP_CYC(GAP_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(cs_fall),
    .en_i    (frame[FRAME_W-1]),
    .code_i  (frame[CODE_W-1:0]),
    .sw_en_o (sw_en_o)
  );

  assign dout_oe_o = cs_high;
endmodule

module chsel_ctrl_chk #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            dout_o,
  input logic            dout_oe_o,
  input logic [N_CH-1:0] sw_en_o,
  input logic            cs_fall_i,
  input logic            sclk_rise_i
);
  // R4
  one_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sw_en_o));

  // R4
  break_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (sw_en_o == '0));

  // R5
  hold_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o != '0 && !cs_fall_i) |=> $stable(sw_en_o));

  // R6
  dout_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_rise_i |=> $stable(dout_o));

  // R7
  oe_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dout_oe_o) |=> (sw_en_o == '0));

  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (sw_en_o == '0 && !dout_oe_o && !dout_o);
    end
  end
endmodule

bind chsel_ctrl chsel_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dout_o     (dout_o),
  .dout_oe_o  (dout_oe_o),
  .sw_en_o    (sw_en_o),
  .cs_fall_i  (cs_fall),
  .sclk_rise_i(sclk_rise)
);

// File: tb/chsel_ctrl_bench.sv
`timescale 1ns/1ps
module chsel_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 4;
  localparam int HOLD       = 4;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sclk = 1'b0, cs = 1'b0, din = 1'b0;
  logic       dout, dout_oe;
  logic [7:0] sw_en;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chsel_ctrl #(.N_CH(8), .GAP_CYC(GAP)) u_chsel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_i(cs), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe), .sw_en_o(sw_en)
  );

  // reference model: input history, bits {sclk,cs,din}, index 0 is newest
  bit [2:0] hist[$];
  int       m_frame[$];
  int       m_sw, m_pend, m_cnt, m_oe, m_dout;

  task automatic model_reset();
    hist = '{3'b000, 3'b000, 3'b000};
    m_frame = '{0, 0, 0, 0};
    m_sw = 0; m_pend = 0; m_cnt = 0; m_oe = 0; m_dout = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit [2:0] h2, h3;
      h2 = hist[1]; h3 = hist[2];
      if (h2[1] && h2[2] && !h3[2]) begin
        void'(m_frame.pop_front());
        m_frame.push_back(int'(h2[0]));
      end
      if (!h2[1] && h3[1]) begin
        m_sw = 0; m_cnt = GAP;
        m_pend = (m_frame[0] == 1) ? (1 << (m_frame[1]*4 + m_frame[2]*2 + m_frame[3])) : 0;
      end else if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_sw = m_pend;
      end
      m_oe = int'(hist[0][1]);
      m_dout = m_frame[0];
      hist.push_front({sclk, cs, din});
      void'(hist.pop_back());
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2/R3/R4/R5 sw_en", int'(sw_en), m_sw);
      check("R7 dout_oe", int'(dout_oe), m_oe);
      if (dout_oe) check("R1/R6 dout", int'(dout), m_dout);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    din = b; sclk = 1'b0; wait_cyc(HOLD);
    sclk = 1'b1; wait_cyc(HOLD);
  endtask

  task automatic send_frame(bit en, int ch);
    cs = 1'b1; wait_cyc(HOLD);
    send_bit(en); send_bit(ch[2]); send_bit(ch[1]); send_bit(ch[0]);
    sclk = 1'b0; wait_cyc(HOLD);
    cs = 1'b0; wait_cyc(GAP + 8);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    wait_cyc(3);
    // R9 reset state
    check("R9 sw_en in reset", int'(sw_en), 0);
    check("R9 dout_oe in reset", int'(dout_oe), 0);
    check("R9 dout in reset", int'(dout), 0);
    rst_n = 1'b1;
    wait_cyc(4);

    // R2 every channel
    for (int ch = 0; ch < 8; ch++) begin
      send_frame(1'b1, ch);
      check("R2 selected channel", int'(sw_en), 1 << ch);
    end

    // R3 disabled frames
    send_frame(1'b0, 5);
    check("R3 enable flag 0", int'(sw_en), 0);
    send_frame(1'b1, 6);
    send_frame(1'b0, 7);
    check("R3 enable flag 0 with code 7", int'(sw_en), 0);

    // R4 gap timing after strobe drop: old for 2 samples, zero for GAP, then new
    send_frame(1'b1, 2);
    cs = 1'b1; wait_cyc(HOLD);
    send_bit(1); send_bit(1); send_bit(0); send_bit(1);
    sclk = 1'b0; wait_cyc(HOLD);
    check("R5 hold during shifting", int'(sw_en), 1 << 2);
    cs = 1'b0;
    for (int i = 1; i <= GAP + 4; i++) begin
      int exp;
      @(negedge clk);
      exp = (i <= 2) ? (1 << 2) : (i <= 2 + GAP) ? 0 : (1 << 5);
      check("R4 gap sequence", int'(sw_en), exp);
    end
    wait_cyc(4);

    // R8 extra edges: 6 bits, last four are 1,1,1,1 -> channel 7
    cs = 1'b1; wait_cyc(HOLD);
    send_bit(0); send_bit(0); send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    sclk = 1'b0; wait_cyc(HOLD);
    cs = 1'b0; wait_cyc(GAP + 8);
    check("R8 last four bits kept", int'(sw_en), 1 << 7);

    // R6 cascade: first bit surfaces after fourth rise
    cs = 1'b1; wait_cyc(HOLD);
    send_bit(1); send_bit(0); send_bit(0); send_bit(0);
    check("R6 dout after fourth rise", int'(dout), 1);
    check("R7 oe high with strobe", int'(dout_oe), 1);
    send_bit(1);
    check("R6 dout after fifth rise", int'(dout), 0);
    sclk = 1'b0; wait_cyc(HOLD);
    cs = 1'b0; wait_cyc(GAP + 8);
    check("R7 oe low after strobe", int'(dout_oe), 0);
    check("R8 cascade frame commit", int'(sw_en), 0);

    // R1 strobe low: clock edges ignored
    send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    sclk = 1'b0;
    cs = 1'b1; wait_cyc(HOLD);
    cs = 1'b0; wait_cyc(GAP + 8);
    check("R1 no shift while strobe low", int'(sw_en), 0);

    wait_cyc(5);
    finish_run();
  end
endmodule